// File: doc/BRIEF.md
# Streaming Max-Pool Comparator with Argmax

This block reduces a window of signed samples to its largest value and the position of that value within the window. Samples arrive two per beat on a valid/ready input stream. Each accepted beat carries a pair, A and B. The block first picks the larger member of the pair. It then tests that candidate against the running maximum held in a register. When the candidate is strictly larger, the register takes the candidate's value and its element index.

A beat flagged as the last of its window closes the window. The final value and index appear on a valid/ready result stream one cycle after that beat is accepted. The running state then clears for the next window without any further command.

A separate plain control pin, `win_start`, discards a partly built window. The pair (if any) accepted in the same cycle as `win_start` becomes pair 0 of a fresh window.

Back-pressure follows these rules:
- A result that has not been taken stays on the result port, unchanged, for as long as `res_ready` is low.
- While such a result waits, `in_ready` is low, so no new beat is accepted.
- `in_ready` is high whenever the result slot is empty, or is being drained in the same cycle.

Top module: `maxpool_argmax_stream`

## Requirements
- R1: After reset, `res_valid` is 0 and `in_ready` is 1.
- R2: Within a pair, the signed larger of A and B becomes the candidate; on equal values A is chosen.
- R3: The stored maximum is replaced only when the candidate is strictly greater (two's-complement compare), so on a tie the earlier element keeps its index.
- R4: The element index of A in pair k of a window is 2k and that of B is 2k+1, pairs counted from 0 at the window's first accepted beat.
- R5: One cycle after a beat with `in_last`=1 is accepted, `res_valid` is 1 with the window's maximum on `res_value` and its index on `res_index`; with `res_ready` held at 1 `res_valid` lasts exactly one cycle.
- R6: While `res_valid`=1 and `res_ready`=0, `in_ready` is 0 and `res_value`/`res_index` stay stable; when `res_ready` returns to 1 the waiting input beat is accepted in that same cycle.
- R7: Beats with `in_valid`=0 change nothing, whatever the data and `in_last` pins carry.
- R8: `win_start`=1 clears the pair count and sets the stored maximum to the most negative value (-128 for 8 bits) with index 0; a beat accepted in the same cycle is pair 0 of the new window.
- R9: After a window closes, the next window starts at pair 0 with the maximum cleared, without any `win_start`; a window made only of -128 reports index 0.
- R10: Negative inputs compare correctly as signed numbers (for example, -3 beats -5 and -4).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| win_start | input | 1 | Abandon the current window and clear the running state |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat can be accepted |
| in_a | input | W (8) | Signed sample A of the pair (even index) |
| in_b | input | W (8) | Signed sample B of the pair (odd index) |
| in_last | input | 1 | This beat closes the window |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer takes the result |
| res_value | output | W (8) | Signed maximum of the window |
| res_index | output | IDX_W (8) | Element index of the maximum |

## Verification
A pair counter that slips, or a maximum register that is not cleared, shows up at the ports only on the next window's result. That result appears one cycle after its last beat, so each case has to be checked on the first result after its stimulus. A wrong tie rule, a lost signed compare or a miscounted index changes `res_index` or `res_value` on that same result. For that reason the vectors plant ties within a pair and across pairs, negative runs, and long windows. A broken stall path shows within the cycle as `in_ready` high, or as a changed result, while `res_ready` is low.

// File: rtl/mp_pkg.sv
package mp_pkg;
  localparam int DEF_W     = 8;
  localparam int DEF_IDX_W = 8;

  typedef enum logic {
    PICK_A = 1'b0,
    PICK_B = 1'b1
  } pick_e;
endpackage

// File: rtl/mp_pair_reduce.sv
// Chooses the larger member of a pair; A is kept when the two are equal.
module mp_pair_reduce #(
  parameter int W = 8
) (
  input  logic signed [W-1:0] a,
  input  logic signed [W-1:0] b,
  output logic signed [W-1:0] cand,
  output mp_pkg::pick_e       pick
);
  always_comb begin
    if (b > a) begin
      pick = mp_pkg::PICK_B;
      cand = b;
    end else begin
      pick = mp_pkg::PICK_A;
      cand = a;
    end
  end
endmodule

// File: rtl/mp_pair_counter.sv
// Pair position within the current window.
module mp_pair_counter #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             fire,
  input  logic             last,
  output logic [CNT_W-1:0] base_cnt
);
  logic [CNT_W-1:0] cnt_q;

  assign base_cnt = start ? '0 : cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (fire) begin
      cnt_q <= last ? '0 : base_cnt + 1'b1;
    end else if (start) begin
      cnt_q <= '0;
    end
  end
endmodule

// File: rtl/mp_running_max.sv
// Running maximum and its index, with the merged next value exposed.
module mp_running_max #(
  parameter int W     = 8,
  parameter int IDX_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               fire,
  input  logic               last,
  input  logic signed [W-1:0] cand,
  input  logic [IDX_W-1:0]   cand_idx,
  output logic signed [W-1:0] nxt_max,
  output logic [IDX_W-1:0]   nxt_idx
);
  localparam logic signed [W-1:0] MIN_VAL = {1'b1, {(W-1){1'b0}}};

  logic signed [W-1:0] max_q;
  logic [IDX_W-1:0]    idx_q;
  logic signed [W-1:0] base_max;
  logic [IDX_W-1:0]    base_idx;

  always_comb begin
    base_max = start ? MIN_VAL : max_q;
    base_idx = start ? '0 : idx_q;
    if (cand > base_max) begin
      nxt_max = cand;
      nxt_idx = cand_idx;
    end else begin
      nxt_max = base_max;
      nxt_idx = base_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      max_q <= MIN_VAL;
      idx_q <= '0;
    end else if (fire && !last) begin
      max_q <= nxt_max;
      idx_q <= nxt_idx;
    end else if (fire || start) begin
      max_q <= MIN_VAL;
      idx_q <= '0;
    end
  end
endmodule

// File: rtl/mp_result_reg.sv
// One-entry result slot on a valid/ready output.
module mp_result_reg #(
  parameter int W     = 8,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [W-1:0]     value,
  input  logic [IDX_W-1:0] index,
  input  logic             res_ready,
  output logic             res_valid,
  output logic [W-1:0]     res_value,
  output logic [IDX_W-1:0] res_index
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_value <= '0;
      res_index <= '0;
    end else if (load) begin
      res_valid <= 1'b1;
      res_value <= value;
      res_index <= index;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/maxpool_argmax_stream.sv
module maxpool_argmax_stream #(
  parameter int W     = mp_pkg::DEF_W,
  parameter int IDX_W = mp_pkg::DEF_IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             win_start,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [W-1:0]     in_a,
  input  logic [W-1:0]     in_b,
  input  logic             in_last,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [W-1:0]     res_value,
  output logic [IDX_W-1:0] res_index
);
  localparam int CNT_W = IDX_W - 1;

  logic                fire;
  logic [CNT_W-1:0]    base_cnt;
  logic signed [W-1:0] cand;
  mp_pkg::pick_e       pick;
  logic [IDX_W-1:0]    cand_idx;
  logic signed [W-1:0] nxt_max;
  logic [IDX_W-1:0]    nxt_idx;

  assign in_ready = !res_valid || res_ready;
  assign fire     = in_valid && in_ready;
  assign cand_idx = {base_cnt, (pick == mp_pkg::PICK_B)};

  mp_pair_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (win_start),
    .fire     (fire),
    .last     (in_last),
    .base_cnt (base_cnt)
  );

  mp_pair_reduce #(.W(W)) u_red (
    .a    ($signed(in_a)),
    .b    ($signed(in_b)),
    .cand (cand),
    .pick (pick)
  );

  mp_running_max #(.W(W), .IDX_W(IDX_W)) u_max (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (win_start),
    .fire     (fire),
    .last     (in_last),
    .cand     (cand),
    .cand_idx (cand_idx),
    .nxt_max  (nxt_max),
    .nxt_idx  (nxt_idx)
  );

  mp_result_reg #(.W(W), .IDX_W(IDX_W)) u_res (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (fire && in_last),
    .value     (nxt_max),
    .index     (nxt_idx),
    .res_ready (res_ready),
    .res_valid (res_valid),
    .res_value (res_value),
    .res_index (res_index)
  );
endmodule

// File: rtl/mp_checker.sv
module mp_checker #(
  parameter int W     = 8,
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             win_start,
  input logic             in_valid,
  input logic             in_ready,
  input logic [W-1:0]     in_a,
  input logic [W-1:0]     in_b,
  input logic             in_last,
  input logic             res_valid,
  input logic             res_ready,
  input logic [W-1:0]     res_value,
  input logic [IDX_W-1:0] res_index
);
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_value) && $stable(res_index))); // R6
  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |-> !in_ready); // R6
  AST_EMPTY_SLOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> in_ready); // R6
  AST_LAST_GIVES_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_last) |=> res_valid); // R5
  AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (!(in_valid && in_ready && in_last) && !(res_valid && !res_ready)) |=> !res_valid); // R5
endmodule

bind maxpool_argmax_stream mp_checker #(.W(W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/sim_maxpool_argmax_stream.sv
`timescale 1ns/1ps
module sim_maxpool_argmax_stream;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       win_start = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_a = '0;
  logic [7:0] in_b = '0;
  logic       in_last = 1'b0;
  logic       res_valid;
  logic       res_ready = 1'b1;
  logic [7:0] res_value;
  logic [7:0] res_index;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  maxpool_argmax_stream u0 (.*);

  // {last, a, b} per beat; five windows
  localparam int NV = 13;
  localparam logic [16:0] VEC [NV] = '{
    {1'b0, 8'sd3,    8'sd7},
    {1'b0, 8'sd7,    8'sd2},
    {1'b1, -8'sd1,   8'sd5},
    {1'b0, -8'sd5,   -8'sd5},
    {1'b1, -8'sd3,   -8'sd4},
    {1'b1, -8'sd128, -8'sd128},
    {1'b0, 8'sd10,   8'sd20},
    {1'b0, 8'sd30,   8'sd40},
    {1'b0, 8'sd50,   8'sd60},
    {1'b1, 8'sd127,  -8'sd128},
    {1'b0, 8'sd1,    8'sd2},
    {1'b0, 8'sd100,  -8'sd7},
    {1'b1, 8'sd0,    8'sd100}
  };
  // {value, index} per window
  localparam int NW = 5;
  localparam logic [15:0] EXP [NW] = '{
    {8'sd7,    8'd1},  // R3 tie across pairs keeps index 1
    {-8'sd3,   8'd2},  // R10 / R2 tie inside pair
    {-8'sd128, 8'd0},  // R9 all minimum
    {8'sd127,  8'd6},  // R4
    {8'sd100,  8'd2}   // R3
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Called and returns at a falling edge; beat accepted in between.
  task automatic send(input logic [7:0] a, input logic [7:0] b, input logic last);
    in_valid = 1'b1; in_a = a; in_b = b; in_last = last;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic check_result(input string req, input int v, input int idx);
    chk({req, " valid"}, int'(res_valid), 1);
    chk({req, " value"}, int'($signed(res_value)), v);
    chk({req, " index"}, int'(res_index), idx);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    int w;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 res_valid", int'(res_valid), 0);
    chk("R1 in_ready", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);

    // vector table walk (R2 R3 R4 R5 R9 R10)
    w = 0;
    for (int i = 0; i < NV; i++) begin
      send(VEC[i][15:8], VEC[i][7:0], VEC[i][16]);
      if (VEC[i][16]) begin
        check_result("R5 table", int'($signed(EXP[w][15:8])), int'(EXP[w][7:0]));
        @(negedge clk);
        chk("R5 single cycle", int'(res_valid), 0);
        w++;
      end
    end

    // R4 long window: a=k, b=-k for k=0..9 -> max 9 at index 18
    for (int k = 0; k < 10; k++) send(8'(k), 8'(-k), k == 9);
    check_result("R4 long", 9, 18);
    @(negedge clk);

    // R7 idle beats with tempting data are ignored
    send(8'sd5, 8'sd1, 1'b0);
    in_a = 8'sd100; in_b = 8'sd100; in_last = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk("R7 no result on idle", int'(res_valid), 0);
    end
    send(8'sd2, 8'sd9, 1'b1);
    check_result("R7 gap", 9, 3);
    @(negedge clk);

    // R6 back-pressure
    res_ready = 1'b0;
    send(8'sd4, 8'sd8, 1'b1);
    check_result("R6 first", 8, 1);
    in_valid = 1'b1; in_a = 8'sd50; in_b = 8'sd50; in_last = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk("R6 in_ready low", int'(in_ready), 0);
      check_result("R6 held", 8, 1);
    end
    res_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    check_result("R6 R9 next window", 50, 0);
    @(negedge clk);

    // R8 start with a beat in the same cycle
    send(8'sd90, 8'sd1, 1'b0);
    win_start = 1'b1;
    send(8'sd3, 8'sd4, 1'b1);
    win_start = 1'b0;
    check_result("R8 start with beat", 4, 1);
    @(negedge clk);

    // R8 start alone
    send(8'sd100, 8'sd0, 1'b0);
    win_start = 1'b1;
    @(negedge clk);
    win_start = 1'b0;
    chk("R8 no result on start", int'(res_valid), 0);
    send(8'sd6, 8'sd2, 1'b1);
    check_result("R8 start alone", 6, 0);
    @(negedge clk);

    finished = 1'b1;
    summary();
  end
endmodule